// File: doc/BRIEF.md
# Read-Ahead Target Read Data Pipeline

This block carries 64-bit read data from a local-side data source to the bus side of a target interface during a read transaction. On the local side it offers an acknowledge, takes a ready from the source, and reports every accepted word with a transfer strobe. The strobe is high in the cycle the word is on the local data input. On the bus side it presents the oldest held word on the address/data output and raises a target-ready output whenever it holds a word. A data phase completes on a clock where target-ready and the master's initiator-ready are both high.

The block keeps fetching ahead of the bus. This lets a burst run with no wait states even though the local source has a one-clock data latency. When the master stalls, the pipeline fills and the local acknowledge is withdrawn. When the local source stalls, the pipeline drains and target-ready drops. Two inputs come from the surrounding target controller. `claimed` is high for as long as the transaction is claimed. `frameOn` is high while the master still wants more data. When `claimed` goes low, every prefetched word that was not delivered is thrown away.

Top module: `read_ahead_pipe`

## Requirements
- R1: While reset is applied, and in the first cycle after it with `claimed` low, `localAck`, `localXfer` and `busTrdy` are 0 and `busAd` is all zeros.
- R2: `localAck` is high only when `claimed` and `frameOn` are both high. In the first cycle of a claim, with `frameOn` high, it is high, so the acknowledge appears in the same clock the transaction is claimed.
- R3: `localXfer` is high in cycle t+1 exactly when `localReady` and `localAck` were both high in cycle t. The word on `localData` in cycle t+1 is the word accepted.
- R4: Accepted words go onto `busAd` in acceptance order, with `busTrdy` high. A word that arrives while the pipeline is empty is driven from the next clock edge. `busAd` is zero whenever `busTrdy` is low.
- R5: In a claim where `localReady` and `busIrdy` stay high and `frameOn` is high for the first five cycles, `busTrdy` is high from the third claimed cycle on. Exactly four data phases complete by the sixth cycle, and five local words are transferred.
- R6: While `busTrdy` is high and `busIrdy` is low, the next cycle (if still claimed) keeps `busTrdy` high and `busAd` unchanged. The acknowledge for cycle t+1 is given only if the words held after the edge, plus the word landing in t+1, plus one stay within DEPTH (default 3). A one-cycle master wait in the fourth cycle of a zero-wait burst therefore drops `localAck` in the fifth cycle.
- R7: In a claim with `busIrdy` high, a single drop of `localReady` in the second claimed cycle lowers `localXfer` in the third cycle and `busTrdy` in the fourth cycle.
- R8: The cycle after `claimed` was low, `busTrdy` is low and no word is held. The first bus word of the next claim is the first word accepted in that claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| claimed | input | 1 | Transaction is claimed; low flushes the pipeline |
| frameOn | input | 1 | Master still requests further data |
| localReady | input | 1 | Local source will present a word next cycle |
| localData | input | 64 | Local read data, valid in the `localXfer` cycle |
| localAck | output | 1 | Pipeline ready to accept a local word |
| localXfer | output | 1 | A local word is being transferred this cycle |
| busIrdy | input | 1 | Master initiator-ready |
| busAd | output | 64 | Read data toward the bus address/data lines |
| busTrdy | output | 1 | Target-ready: `busAd` holds valid data |

## Verification
Some behaviours are checked by the embedded assertions on every cycle. The acknowledge is gated by the claim and frame inputs and is present in the claim cycle. The transfer strobe always follows an accepted ready. Data and target-ready are held across master waits. No word is pushed into a full pipeline. Target-ready is off after a claim ends. Word order and content, the five-for-four read-ahead count, the exact cycles where the acknowledge drops after a master wait, the cycle where target-ready drops after a local stall, and the discard of leftover words across transactions are shown only by the bench's directed scenarios and its cycle model over random traffic.

// File: rtl/rap_pkg.sv
package rap_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } pipeStrobes_t;
endpackage

// File: rtl/rap_datapath.sv
module rap_datapath
  import rap_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipeStrobes_t      ctl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] entryArr [DEPTH];
  logic              doPush, doPop;

  assign doPush = ctl.push && !ctl.flush;
  assign doPop  = ctl.pop && !ctl.flush;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (doPush && wrPtr == PTR_W'(i)) q <= dataIn;
    end
    assign entryArr[i] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = entryArr[rdPtr];
  assign empty = (count == '0);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doPush && !doPop && count == CNT_W'(DEPTH)));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doPop && count == '0));
endmodule

// File: rtl/rap_ctrl.sv
module rap_ctrl
  import rap_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             claimed,
  input  logic             frameOn,
  input  logic             localReady,
  input  logic             busIrdy,
  input  logic [CNT_W-1:0] count,
  input  logic             empty,
  output logic             localAck,
  output logic             localXfer,
  output logic             busTrdy,
  output pipeStrobes_t     ctl
);
  localparam int SUM_W = CNT_W + 2;

  logic             allowQ, strobeQ, takeNow;
  logic [SUM_W-1:0] occNext, need;

  assign localAck  = claimed && frameOn && allowQ;
  assign takeNow   = localReady && localAck;
  assign localXfer = strobeQ;
  assign busTrdy   = claimed && !empty;

  assign ctl.flush = !claimed;
  assign ctl.push  = strobeQ && claimed;
  assign ctl.pop   = busTrdy && busIrdy;

  always_comb begin
    occNext = SUM_W'(count) + SUM_W'(ctl.push) - SUM_W'(ctl.pop);
    need    = occNext + SUM_W'(takeNow) + SUM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !claimed) begin
      allowQ  <= 1'b1;
      strobeQ <= 1'b0;
    end else begin
      allowQ  <= (need <= SUM_W'(DEPTH));
      strobeQ <= takeNow;
    end
  end

  // R2
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    localAck |-> (claimed && frameOn));

  // R2
  ack_on_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (claimed && frameOn && !$past(claimed)) |-> localAck);

  // R3
  xfer_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    localXfer |-> $past(localReady && localAck));

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!claimed) |-> !busTrdy);
endmodule

// File: rtl/read_ahead_pipe.sv
module read_ahead_pipe
  import rap_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              claimed,
  input  logic              frameOn,
  input  logic              localReady,
  input  logic [DATA_W-1:0] localData,
  output logic              localAck,
  output logic              localXfer,
  input  logic              busIrdy,
  output logic [DATA_W-1:0] busAd,
  output logic              busTrdy
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  pipeStrobes_t      ctl;
  logic [CNT_W-1:0]  count;
  logic              empty;
  logic [DATA_W-1:0] head;

  rap_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .claimed(claimed), .frameOn(frameOn),
    .localReady(localReady), .busIrdy(busIrdy), .count(count), .empty(empty),
    .localAck(localAck), .localXfer(localXfer), .busTrdy(busTrdy), .ctl(ctl)
  );

  rap_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(localData),
    .head(head), .count(count), .empty(empty)
  );

  assign busAd = busTrdy ? head : '0;

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (claimed && $past(claimed && busTrdy && !busIrdy)) |->
      (busTrdy && busAd == $past(busAd)));
endmodule

// File: tb/tb_read_ahead_pipe.sv
`timescale 1ns/1ps
module tb_read_ahead_pipe;
  localparam int DEPTH = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        claimed, frameOn, localReady, busIrdy;
  logic [63:0] localData;
  logic        localAck, localXfer, busTrdy;
  logic [63:0] busAd;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;

  logic [63:0] mq[$];
  logic        mStrobe, mAllow;
  int          nXfer, nPhase, cIdx;
  logic        ackSeen [0:15];
  logic        xferSeen[0:15];
  logic        trdySeen[0:15];

  read_ahead_pipe #(.DATA_W(64), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .claimed(claimed), .frameOn(frameOn),
    .localReady(localReady), .localData(localData), .localAck(localAck),
    .localXfer(localXfer), .busIrdy(busIrdy), .busAd(busAd), .busTrdy(busTrdy)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cycle);
    end
  endtask

  function automatic logic expAckF();
    return claimed && frameOn && mAllow;
  endfunction

  // one clock: drive, compare against model, advance model
  task automatic step(input logic cl, input logic fr, input logic rd, input logic ir);
    logic eAck, eTrdy, pop, take;
    logic [63:0] eAd;
    int occ;
    claimed = cl; frameOn = fr; localReady = rd; busIrdy = ir;
    localData = {$urandom, $urandom};
    #1;
    eAck  = expAckF();
    eTrdy = claimed && (mq.size() > 0);
    eAd   = eTrdy ? mq[0] : 64'h0;
    check("R2", "localAck", 64'(localAck), 64'(eAck));
    check("R3", "localXfer", 64'(localXfer), 64'(mStrobe));
    check("R4", "busTrdy", 64'(busTrdy), 64'(eTrdy));
    check("R4", "busAd", busAd, eAd);
    if (cIdx < 16) begin
      ackSeen[cIdx] = localAck; xferSeen[cIdx] = localXfer; trdySeen[cIdx] = busTrdy;
    end
    if (localXfer) nXfer++;
    if (busTrdy && busIrdy) nPhase++;
    cIdx++;
    pop  = eTrdy && ir;
    take = rd && eAck;
    @(posedge clk);
    if (!cl) begin
      mq.delete(); mStrobe = 1'b0; mAllow = 1'b1;
    end else begin
      if (pop) void'(mq.pop_front());
      if (mStrobe) mq.push_back(localData);
      occ = mq.size();
      mAllow  = (occ + int'(take) + 1) <= DEPTH;
      mStrobe = take;
    end
    @(negedge clk);
  endtask

  task automatic startScenario();
    nXfer = 0; nPhase = 0; cIdx = 0;
    for (int i = 0; i < 16; i++) begin
      ackSeen[i] = 1'b0; xferSeen[i] = 1'b0; trdySeen[i] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; claimed = 1'b0; frameOn = 1'b0; localReady = 1'b0;
    busIrdy = 1'b0; localData = '0;
    mStrobe = 1'b0; mAllow = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1", "localAck in reset", 64'(localAck), 64'h0);
    check("R1", "localXfer in reset", 64'(localXfer), 64'h0);
    check("R1", "busTrdy in reset", 64'(busTrdy), 64'h0);
    check("R1", "busAd in reset", busAd, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busTrdy after reset", 64'(busTrdy), 64'h0);
    check("R1", "localXfer after reset", 64'(localXfer), 64'h0);

    // R5: zero-wait burst, four phases
    startScenario();
    for (int c = 0; c < 7; c++) step(c < 7 && c != 6, c < 5, 1'b1, 1'b1);
    check("R2", "ack in claim cycle", 64'(ackSeen[0]), 64'h1);
    check("R5", "local words", 64'(nXfer), 64'd5);
    check("R5", "bus phases", 64'(nPhase), 64'd4);
    check("R5", "trdy cycle 2", 64'(trdySeen[2]), 64'h1);
    check("R5", "trdy cycle 1", 64'(trdySeen[1]), 64'h0);
    step(1'b0, 1'b0, 1'b0, 1'b0);

    // R6: master wait in the fourth claimed cycle
    startScenario();
    for (int c = 0; c < 8; c++) step(1'b1, c < 6, 1'b1, c != 3);
    check("R6", "ack before wait", 64'(ackSeen[3]), 64'h1);
    check("R6", "ack after wait", 64'(ackSeen[4]), 64'h0);
    check("R6", "trdy held in wait", 64'(trdySeen[4]), 64'h1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    // R8: after the flush, no word is held
    check("R8", "trdy after flush", 64'(busTrdy), 64'h0);

    // R7: local stall in the second claimed cycle
    startScenario();
    for (int c = 0; c < 6; c++) step(1'b1, 1'b1, c != 1, 1'b1);
    check("R7", "xfer after stall", 64'(xferSeen[2]), 64'h0);
    check("R7", "trdy two after stall", 64'(trdySeen[3]), 64'h0);
    check("R7", "trdy before gap", 64'(trdySeen[2]), 64'h1);
    step(1'b0, 1'b0, 1'b0, 1'b0);

    // R8: leftovers discarded; the next claim starts with its own first word
    startScenario();
    for (int c = 0; c < 5; c++) step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", "no held word after claim end", 64'(busTrdy), 64'h0);
    for (int c = 0; c < 4; c++) step(1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);

    // random traffic against the cycle model (R2, R3, R4, R6, R8)
    void'($urandom(32'h5eed_0467));
    for (int t = 0; t < 300; t++) begin
      int len, fr;
      len = 2 + int'($urandom_range(0, 18));
      fr  = 1 + int'($urandom_range(0, len));
      for (int c = 0; c < len; c++)
        step(1'b1, c < fr, $urandom_range(0, 9) < 8, $urandom_range(0, 9) < 7);
      for (int g = 0; g <= int'($urandom_range(0, 2)); g++)
        step(1'b0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule